// File: doc/BRIEF.md
# Level-Sensitive Masked Interrupt Controller

This block gathers a set of level-sensitive interrupt request lines, each already synchronous to the block clock, into a pending register. The pending register simply mirrors the current line levels. A software-programmed enable mask is ANDed with the pending bits. If any enabled line is pending, the single interrupt output to the processor goes high. Software clears a request only by removing its source or by masking it, because pending bits are never latched.

A simple word-wide register port gives access to the block. A 32-bit mask register can be read and written, and a status word returns the pending bits. Two further addresses accept writes that change nothing. Any access to an address the block does not define is reported on a one-cycle error strobe. Read data and the error strobe are registered and appear in the cycle after the request. The interrupt output is also registered, and it responds in the cycle after a line changes or the mask is written.

Top module: `lvl_irq_ctrl`

## Requirements
- R1: After synchronous reset the mask and pending state are zero, irq_out is low, bus_rdata is zero and bus_err is low.
- R2: A read of address 0x0C returns, one cycle later, the line levels that were present in the cycle before the read edge, so a bit reads 1 while its line is held high and 0 once it is held low.
- R3: In the cycle after each clock edge, irq_out equals the OR over all bits of (mask after that edge AND the line levels sampled at that edge).
- R4: A write to address 0x04 stores the full 32-bit write data as the mask, and a later read of 0x04 returns it.
- R5: Writes to addresses 0x00 and 0x14 leave the mask, pending state and irq_out unchanged and do not raise bus_err.
- R6: A read of any address other than 0x04 and 0x0C returns zero.
- R7: A write to any address other than 0x00, 0x04 and 0x14 changes no state.
- R8: bus_err is high for exactly the one cycle after an edge at which a read to an address outside {0x04, 0x0C} or a write to an address outside {0x00, 0x04, 0x14} was requested, and is low otherwise.
- R9: bus_rdata is zero in every cycle that follows an edge without a read request.
- R10: A write to the status address 0x0C is treated as undefined: it changes no state and raises bus_err.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr_en | input | 1 | Write request for this cycle |
| bus_rd_en | input | 1 | Read request for this cycle |
| bus_addr | input | 8 | Byte address of the word register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read, zero otherwise |
| bus_err | output | 1 | One-cycle strobe after an access to an undefined address |
| irq_lines | input | NUM_LINES | Level-sensitive request lines, synchronous to clk |
| irq_out | output | 1 | Registered interrupt output to the processor |

## Verification
A corrupted mask shows up at irq_out in the next cycle, as soon as a line it wrongly enables or disables goes high. It also shows up on the next read of 0x04. A stale or stuck pending bit shows up on the next status read, and through irq_out once that bit is enabled. The random mix of line patterns, mask values and addresses makes both kinds of fault visible within a few cycles. A decode fault shows at once as a wrong bus_err strobe or as nonzero data from an address that should read zero.

// File: rtl/lvl_irq_pkg.sv
package lvl_irq_pkg;

    localparam int unsigned REG_W  = 32;
    localparam int unsigned ADDR_W = 8;

    // Address map: the mask and status offsets are what software decodes.
    localparam logic [ADDR_W-1:0] OFF_NOP_LO = 8'h00;
    localparam logic [ADDR_W-1:0] OFF_MASK   = 8'h04;
    localparam logic [ADDR_W-1:0] OFF_STAT   = 8'h0C;
    localparam logic [ADDR_W-1:0] OFF_NOP_HI = 8'h14;

    typedef enum logic [2:0] {
        ACC_NONE,
        ACC_MASK,
        ACC_STAT,
        ACC_NOP,
        ACC_BAD
    } acc_kind_e;

    typedef struct packed {
        logic              wr;
        logic              rd;
        logic [ADDR_W-1:0] addr;
        logic [REG_W-1:0]  wdata;
    } bus_req_t;

    typedef struct packed {
        acc_kind_e wr_kind;
        acc_kind_e rd_kind;
        logic      bad;
    } bus_dec_t;

    function automatic acc_kind_e classify_wr(input logic [ADDR_W-1:0] a);
        acc_kind_e k;
        case (a)
            OFF_MASK:               k = ACC_MASK;
            OFF_NOP_LO, OFF_NOP_HI: k = ACC_NOP;
            default:                k = ACC_BAD;
        endcase
        return k;
    endfunction

    function automatic acc_kind_e classify_rd(input logic [ADDR_W-1:0] a);
        acc_kind_e k;
        case (a)
            OFF_MASK: k = ACC_MASK;
            OFF_STAT: k = ACC_STAT;
            default:  k = ACC_BAD;
        endcase
        return k;
    endfunction

endpackage

// File: rtl/irq_bus_decode.sv
module irq_bus_decode
    import lvl_irq_pkg::*;
(
    input  bus_req_t req,
    output bus_dec_t dec
);

    always_comb begin
        dec.wr_kind = req.wr ? classify_wr(req.addr) : ACC_NONE;
        dec.rd_kind = req.rd ? classify_rd(req.addr) : ACC_NONE;
        dec.bad     = (dec.wr_kind == ACC_BAD) || (dec.rd_kind == ACC_BAD);
    end

endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg
    import lvl_irq_pkg::*;
#(
    parameter int unsigned NUM_LINES = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_hit,
    input  logic [REG_W-1:0]     wdata,
    output logic [NUM_LINES-1:0] mask_q,
    output logic [NUM_LINES-1:0] mask_nxt
);

    always_comb begin
        mask_nxt = wr_hit ? wdata[NUM_LINES-1:0] : mask_q;
    end

    always_ff @(posedge clk) begin
        if (rst) mask_q <= '0;
        else     mask_q <= mask_nxt;
    end

    // R7: without a decoded mask write the mask keeps its value
    a_r7_mask_hold: assert property (@(posedge clk) disable iff (rst)
        !wr_hit |=> $stable(mask_q));

endmodule

// File: rtl/irq_pend_track.sv
module irq_pend_track #(
    parameter int unsigned NUM_LINES = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_LINES-1:0] lines,
    output logic [NUM_LINES-1:0] pend_q
);

    always_ff @(posedge clk) begin
        if (rst) pend_q <= '0;
        else     pend_q <= lines;
    end

    // R2: pending mirrors the line levels from one cycle earlier
    a_r2_pend_mirror: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (pend_q == $past(lines)));

endmodule

// File: rtl/irq_out_stage.sv
module irq_out_stage #(
    parameter int unsigned NUM_LINES = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_LINES-1:0] mask_nxt,
    input  logic [NUM_LINES-1:0] lines,
    output logic                 irq_q
);

    logic [NUM_LINES-1:0] live;

    always_comb begin
        live = mask_nxt & lines;
    end

    always_ff @(posedge clk) begin
        if (rst) irq_q <= 1'b0;
        else     irq_q <= |live;
    end

endmodule

// File: rtl/irq_read_port.sv
module irq_read_port
    import lvl_irq_pkg::*;
#(
    parameter int unsigned NUM_LINES = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  bus_dec_t             dec,
    input  logic [NUM_LINES-1:0] mask_q,
    input  logic [NUM_LINES-1:0] pend_q,
    output logic [REG_W-1:0]     rdata_q,
    output logic                 err_q
);

    localparam int unsigned PAD = REG_W - NUM_LINES;

    logic [REG_W-1:0] mask_w;
    logic [REG_W-1:0] pend_w;
    logic [REG_W-1:0] rdata_d;

    generate
        if (PAD > 0) begin : g_pad
            assign mask_w = {{PAD{1'b0}}, mask_q};
            assign pend_w = {{PAD{1'b0}}, pend_q};
        end else begin : g_full
            assign mask_w = mask_q;
            assign pend_w = pend_q;
        end
    endgenerate

    always_comb begin
        case (dec.rd_kind)
            ACC_MASK: rdata_d = mask_w;
            ACC_STAT: rdata_d = pend_w;
            default:  rdata_d = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q <= '0;
            err_q   <= 1'b0;
        end else begin
            rdata_q <= rdata_d;
            err_q   <= dec.bad;
        end
    end

    // R9: no read request, zero data in the following cycle
    a_r9_idle_zero: assert property (@(posedge clk) disable iff (rst)
        (dec.rd_kind == ACC_NONE) |=> (rdata_q == '0));

endmodule

// File: rtl/lvl_irq_ctrl.sv
module lvl_irq_ctrl
    import lvl_irq_pkg::*;
#(
    parameter int unsigned NUM_LINES = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bus_wr_en,
    input  logic                 bus_rd_en,
    input  logic [7:0]           bus_addr,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    output logic                 bus_err,
    input  logic [NUM_LINES-1:0] irq_lines,
    output logic                 irq_out
);

    bus_req_t             req;
    bus_dec_t             dec;
    logic [NUM_LINES-1:0] mask_q;
    logic [NUM_LINES-1:0] mask_nxt;
    logic [NUM_LINES-1:0] pend_q;
    logic                 mask_wr;

    always_comb begin
        req.wr    = bus_wr_en;
        req.rd    = bus_rd_en;
        req.addr  = bus_addr;
        req.wdata = bus_wdata;
        mask_wr   = (dec.wr_kind == ACC_MASK);
    end

    irq_bus_decode u_dec (
        .req (req),
        .dec (dec)
    );

    irq_mask_reg #(.NUM_LINES(NUM_LINES)) u_mask (
        .clk      (clk),
        .rst      (rst),
        .wr_hit   (mask_wr),
        .wdata    (req.wdata),
        .mask_q   (mask_q),
        .mask_nxt (mask_nxt)
    );

    irq_pend_track #(.NUM_LINES(NUM_LINES)) u_pend (
        .clk    (clk),
        .rst    (rst),
        .lines  (irq_lines),
        .pend_q (pend_q)
    );

    irq_out_stage #(.NUM_LINES(NUM_LINES)) u_out (
        .clk      (clk),
        .rst      (rst),
        .mask_nxt (mask_nxt),
        .lines    (irq_lines),
        .irq_q    (irq_out)
    );

    irq_read_port #(.NUM_LINES(NUM_LINES)) u_rd (
        .clk     (clk),
        .rst     (rst),
        .dec     (dec),
        .mask_q  (mask_q),
        .pend_q  (pend_q),
        .rdata_q (bus_rdata),
        .err_q   (bus_err)
    );

    // R3: registered output agrees with the stored mask and pending state
    a_r3_irq_state: assert property (@(posedge clk) disable iff (rst)
        irq_out == |(mask_q & pend_q));

    // R8: the error strobe only follows an actual access
    a_r8_err_cause: assert property (@(posedge clk) disable iff (rst)
        bus_err |-> $past(bus_wr_en || bus_rd_en));

    // R5: a write to a do-nothing address leaves the mask alone and is not flagged
    a_r5_nop_write: assert property (@(posedge clk) disable iff (rst)
        (bus_wr_en && !bus_rd_en && (bus_addr == OFF_NOP_LO || bus_addr == OFF_NOP_HI))
        |=> ($stable(mask_q) && !bus_err));

    // R10: a write to the status address is flagged
    a_r10_stat_write: assert property (@(posedge clk) disable iff (rst)
        (bus_wr_en && bus_addr == OFF_STAT) |=> bus_err);

endmodule

// File: tb/lvl_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module lvl_irq_ctrl_tb_top;

    localparam int N = 32;

    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en, rd_en;
    logic [7:0]  addr;
    logic [31:0] wdata;
    logic [31:0] rdata;
    logic        err;
    logic [N-1:0] lines;
    logic        irq;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    logic [31:0] m_mask;
    logic [31:0] m_pend;

    always #2 clk = ~clk;

    lvl_irq_ctrl #(.NUM_LINES(N)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .bus_wr_en (wr_en),
        .bus_rd_en (rd_en),
        .bus_addr  (addr),
        .bus_wdata (wdata),
        .bus_rdata (rdata),
        .bus_err   (err),
        .irq_lines (lines),
        .irq_out   (irq)
    );

    function automatic bit wr_legal(input logic [7:0] a);
        return (a == 8'h00) || (a == 8'h04) || (a == 8'h14);
    endfunction

    function automatic bit rd_legal(input logic [7:0] a);
        return (a == 8'h04) || (a == 8'h0C);
    endfunction

    function automatic logic [31:0] rd_expect(input logic [7:0] a,
                                              input logic [31:0] mk,
                                              input logic [31:0] pd);
        if (a == 8'h04) return mk;
        if (a == 8'h0C) return pd;
        return 32'h0;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One bus cycle: drive at negedge, model the edge, check after it.
    task automatic step(input bit w, input bit r, input logic [7:0] a,
                        input logic [31:0] d, input logic [N-1:0] ln);
        logic [31:0] e_rd;
        bit          e_err;
        string       rtag;
        @(negedge clk);
        wr_en = w; rd_en = r; addr = a; wdata = d; lines = ln;
        e_rd  = r ? rd_expect(a, m_mask, m_pend) : 32'h0;
        e_err = (w && !wr_legal(a)) || (r && !rd_legal(a));
        if (w && a == 8'h04) m_mask = d;
        m_pend = ln;
        @(posedge clk);
        #1;
        if (!r)              rtag = "R9 idle rdata";
        else if (a == 8'h04) rtag = "R4 mask read";
        else if (a == 8'h0C) rtag = "R2 status read";
        else                 rtag = "R6 undefined read";
        check(rtag, rdata, e_rd);
        check("R8 bus_err", {31'h0, err}, {31'h0, e_err});
        check("R3 irq_out", {31'h0, irq}, {31'h0, |(m_mask & m_pend)});
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] pick [9];
        void'($urandom(32'h5EED_0017));
        pick = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h10, 8'h14, 8'h18, 8'h03, 8'hFC};
        rst = 1'b1; wr_en = 0; rd_en = 0; addr = 0; wdata = 0; lines = '1;
        m_mask = 0; m_pend = 0;
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        check("R1 irq_out reset", {31'h0, irq}, 32'h0);
        check("R1 rdata reset", rdata, 32'h0);
        check("R1 err reset", {31'h0, err}, 32'h0);
        @(negedge clk);
        rst = 1'b0; lines = '0;
        step(0, 1, 8'h04, 0, '0);                    // R1 mask reads zero
        step(0, 1, 8'h0C, 0, '0);                    // R1 pending zero

        // R4 full-width mask write and readback
        step(1, 0, 8'h04, 32'hFFFF_FFFF, '0);
        step(0, 1, 8'h04, 0, '0);
        step(1, 0, 8'h04, 32'h8000_0001, '0);
        step(0, 1, 8'h04, 0, '0);
        // R3 line 31 enabled, line 30 not
        step(0, 0, 8'h00, 0, 32'h4000_0000);
        step(0, 0, 8'h00, 0, 32'h8000_0000);
        step(0, 1, 8'h0C, 0, 32'h8000_0000);         // R2 status shows bit 31
        step(0, 1, 8'h0C, 0, 32'h0);                 // R2 drop: still old level
        step(0, 1, 8'h0C, 0, 32'h0);                 // R2 now cleared
        // R5 do-nothing writes
        step(1, 0, 8'h00, 32'h0, 32'h1);
        step(1, 0, 8'h14, 32'h0, 32'h1);
        step(0, 1, 8'h04, 0, 32'h1);
        // R10 write to status, R7 write to undefined
        step(1, 0, 8'h0C, 32'h0, 32'h1);
        step(1, 0, 8'h08, 32'h0, 32'h1);
        step(1, 0, 8'h05, 32'h0, 32'h1);
        step(0, 1, 8'h04, 0, 32'h1);
        // R6 reads of other offsets
        step(0, 1, 8'h00, 0, 32'hFFFF_FFFF);
        step(0, 1, 8'h14, 0, 32'hFFFF_FFFF);
        step(0, 1, 8'h10, 0, 32'hFFFF_FFFF);
        // mask write and line change in the same cycle
        step(1, 0, 8'h04, 32'h0000_0100, 32'h0000_0100);
        step(1, 1, 8'h04, 32'h0, 32'h0000_0100);

        for (int i = 0; i < 3000; i++) begin
            int unsigned op = $urandom_range(0, 9);
            logic [7:0]  a  = pick[$urandom_range(0, 8)];
            logic [31:0] d  = ($urandom_range(0, 3) == 0) ? (32'h1 << $urandom_range(0, 31)) : $urandom;
            logic [31:0] ln = ($urandom_range(0, 1) == 0) ? 32'h0 : ($urandom & $urandom);
            step(op < 3, (op >= 3 && op < 6) || op == 9, a, d, ln);
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule